// File: doc/BRIEF.md
# Windowed Single-Channel Memory Transfer Engine

This block moves 16-bit words between a peripheral data bus and an external asynchronous SRAM with no processor in the loop. Before a run, a host fills in four setup registers through a plain register-write port: a window start address, a window final address, a word count, and a control register. The control register holds the transfer direction, a three-bit reference clock profile that is passed straight out to the clock generator, and the arm bit. The arm bit is always written last.

While armed, every clock cycle in which the peripheral holds its transfer strobe high moves one word at the current SRAM address, then steps the address up by one and the remaining count down by one. The run ends when the count runs out or when the word at the final address of the window has moved, whichever comes first. At that point the busy indication drops, a done latch sets, and strobes are ignored until the host arms again. The host can read back every setup register, plus the live address and the remaining count, at any time and without disturbing a run.

Top module: `wdma_engine`

## Requirements
- R1: After reset the engine is idle and not done, both SRAM enables (active low) are high, the profile output is 0, and every register offset reads 0.
- R2: Offsets 0 (window start), 1 (window final) and 2 (word count) are 24-bit registers that read back the value last written. Offset 3 (control) reads back bit 7 busy, bit 6 done, bit 4 direction, bits 2:0 profile, and 0 in bits 5, 3 and 23:8.
- R3: Writing offset 3 with bit 7 set arms the engine. The live address at offset 4 is loaded from the window start, the remaining count at offset 5 is loaded from the word count, and the done bit is cleared.
- R4: Each cycle in which the strobe is high while the engine is busy moves one word at the current address. After that cycle the address is one higher and the remaining count is one lower.
- R5: With direction bit 4 = 1 (device to memory), the write enable is low exactly during a transfer cycle, the output enable stays high, and the SRAM data output carries the device data input.
- R6: With direction bit 4 = 0 (memory to device), the output enable is low exactly during a transfer cycle, the write enable stays high, and the device data output carries the SRAM data input.
- R7: A transfer made with a remaining count of 1 clears busy and sets done on the next cycle.
- R8: A transfer made at the window final address clears busy and sets done even when count remains. The live address then reads final + 1.
- R9: While the engine is not busy, strobes change neither the address nor the count, and both SRAM enables stay high.
- R10: Any write to offset 3 clears the done latch. Arming with a word count of 0 sets done at once and never goes busy.
- R11: The profile output equals control bits 2:0 and changes only on a write to offset 3.
- R12: Reading offsets 4 and 5 during a run does not change the address sequence or the number of words moved.
- R13: Writing offset 3 with bit 7 clear while busy stops the run at once, and later strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register offset for write and read |
| regWrData | input | 24 | Register write data |
| regRdData | output | 24 | Read data for the register at regAddr |
| xferStb | input | 1 | Peripheral transfer strobe, one word per high cycle |
| devDataIn | input | 16 | Data from the peripheral |
| devDataOut | output | 16 | Data to the peripheral |
| memAddr | output | 24 | SRAM address |
| memDataIn | input | 16 | Data read from SRAM |
| memDataOut | output | 16 | Data written to SRAM |
| memWeN | output | 1 | SRAM write enable, active low |
| memOeN | output | 1 | SRAM output enable, active low |
| clkSel | output | 3 | Reference clock profile select |

## Verification
The bench aims at the two ways a run can end. A window that closes before the count runs out catches a design that watches only the count; such a design would keep writing past the final address. A count that runs out well inside a huge window catches the opposite mistake. It also arms with a zero count, which a careless design would turn into a run of 16M words. It sends strobes after completion and after an early disarm, where a design that gates only on done or only on arm would still move the address or pulse an enable. Mid-run reads of the live registers check that reading has no side effects, and the done bit is watched across re-arming, because a latch that never clears would report a fresh run as finished.

// File: rtl/wdma_pkg.sv
package wdma_pkg;

  typedef enum logic [2:0] {
    REG_START   = 3'd0,
    REG_FINAL   = 3'd1,
    REG_COUNT   = 3'd2,
    REG_CTRL    = 3'd3,
    REG_CURADDR = 3'd4,
    REG_REMAIN  = 3'd5
  } regSel_e;

  localparam int CTRL_ARM_BIT  = 7;
  localparam int CTRL_DONE_BIT = 6;
  localparam int CTRL_DIR_BIT  = 4;
  localparam int PROF_W        = 3;
  localparam int CTRL_W        = 8;

  // Strobes sent from control to datapath
  typedef struct packed {
    logic load;   // arm: reload address and count
    logic step;   // one word moves this cycle
  } dpStrobes_t;

endpackage

// File: rtl/wdma_ctrl.sv
module wdma_ctrl
  import wdma_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [ADDR_W-1:0] regRdData,
  input  logic              xferStb,
  input  logic              lastXfer,
  input  logic [ADDR_W-1:0] curAddr,
  input  logic [ADDR_W-1:0] remCnt,
  output dpStrobes_t        strb,
  output logic [ADDR_W-1:0] startAddr,
  output logic [ADDR_W-1:0] finalAddr,
  output logic [ADDR_W-1:0] xferCount,
  output logic              dirToMem,
  output logic              busy,
  output logic              done,
  output logic [PROF_W-1:0] clkSel
);

  localparam int PAD_W = ADDR_W - CTRL_W;

  logic              ctrlWr;
  logic              busyQ, doneQ, dirQ;
  logic [PROF_W-1:0] profQ;
  logic [ADDR_W-1:0] startQ, finalQ, countQ;
  logic [CTRL_W-1:0] ctrlView;

  assign ctrlWr    = regWrEn && (regAddr == REG_CTRL);
  assign strb.load = ctrlWr && regWrData[CTRL_ARM_BIT];
  // A control write in the same cycle takes priority over a strobe
  assign strb.step = busyQ && xferStb && !ctrlWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= '0;
      finalQ <= '0;
      countQ <= '0;
      busyQ  <= 1'b0;
      doneQ  <= 1'b0;
      dirQ   <= 1'b0;
      profQ  <= '0;
    end else begin
      if (regWrEn && regAddr == REG_START) startQ <= regWrData;
      if (regWrEn && regAddr == REG_FINAL) finalQ <= regWrData;
      if (regWrEn && regAddr == REG_COUNT) countQ <= regWrData;
      if (ctrlWr) begin
        dirQ  <= regWrData[CTRL_DIR_BIT];
        profQ <= regWrData[PROF_W-1:0];
        busyQ <= regWrData[CTRL_ARM_BIT] && (countQ != '0);
        doneQ <= regWrData[CTRL_ARM_BIT] && (countQ == '0);
      end else if (strb.step && lastXfer) begin
        busyQ <= 1'b0;
        doneQ <= 1'b1;
      end
    end
  end

  always_comb begin
    ctrlView = '0;
    ctrlView[CTRL_ARM_BIT]  = busyQ;
    ctrlView[CTRL_DONE_BIT] = doneQ;
    ctrlView[CTRL_DIR_BIT]  = dirQ;
    ctrlView[PROF_W-1:0]    = profQ;
  end

  always_comb begin
    case (regAddr)
      REG_START:   regRdData = startQ;
      REG_FINAL:   regRdData = finalQ;
      REG_COUNT:   regRdData = countQ;
      REG_CTRL:    regRdData = {{PAD_W{1'b0}}, ctrlView};
      REG_CURADDR: regRdData = curAddr;
      REG_REMAIN:  regRdData = remCnt;
      default:     regRdData = '0;
    endcase
  end

  assign startAddr = startQ;
  assign finalAddr = finalQ;
  assign xferCount = countQ;
  assign dirToMem  = dirQ;
  assign busy      = busyQ;
  assign done      = doneQ;
  assign clkSel    = profQ;

endmodule

// File: rtl/wdma_datapath.sv
module wdma_datapath
  import wdma_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] finalAddr,
  input  logic [ADDR_W-1:0] xferCount,
  input  logic              dirToMem,
  input  logic [DATA_W-1:0] devDataIn,
  input  logic [DATA_W-1:0] memDataIn,
  output logic [ADDR_W-1:0] curAddr,
  output logic [ADDR_W-1:0] remCnt,
  output logic              lastXfer,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDataOut,
  output logic [DATA_W-1:0] devDataOut,
  output logic              memWeN,
  output logic              memOeN
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] addrQ, remQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      remQ  <= '0;
    end else if (strb.load) begin
      addrQ <= startAddr;
      remQ  <= xferCount;
    end else if (strb.step) begin
      addrQ <= addrQ + ONE;
      remQ  <= remQ - ONE;
    end
  end

  // Terminal when the count expires or the window end is reached
  assign lastXfer = (remQ == ONE) || (addrQ == finalAddr);

  assign memWeN     = !(strb.step && dirToMem);
  assign memOeN     = !(strb.step && !dirToMem);
  assign memAddr    = addrQ;
  assign memDataOut = devDataIn;
  assign devDataOut = memDataIn;
  assign curAddr    = addrQ;
  assign remCnt     = remQ;

endmodule

// File: rtl/wdma_engine.sv
module wdma_engine
  import wdma_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [ADDR_W-1:0] regRdData,
  input  logic              xferStb,
  input  logic [DATA_W-1:0] devDataIn,
  output logic [DATA_W-1:0] devDataOut,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memDataIn,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memWeN,
  output logic              memOeN,
  output logic [PROF_W-1:0] clkSel
);

  dpStrobes_t        strb;
  logic              lastXfer, dirToMem, busy, done;
  logic [ADDR_W-1:0] curAddr, remCnt, startAddr, finalAddr, xferCount;

  wdma_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .xferStb(xferStb),
    .lastXfer(lastXfer), .curAddr(curAddr), .remCnt(remCnt), .strb(strb),
    .startAddr(startAddr), .finalAddr(finalAddr), .xferCount(xferCount),
    .dirToMem(dirToMem), .busy(busy), .done(done), .clkSel(clkSel)
  );

  wdma_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .startAddr(startAddr),
    .finalAddr(finalAddr), .xferCount(xferCount), .dirToMem(dirToMem),
    .devDataIn(devDataIn), .memDataIn(memDataIn), .curAddr(curAddr),
    .remCnt(remCnt), .lastXfer(lastXfer), .memAddr(memAddr),
    .memDataOut(memDataOut), .devDataOut(devDataOut),
    .memWeN(memWeN), .memOeN(memOeN)
  );

endmodule

// File: rtl/wdma_engine_chk.sv
module wdma_engine_chk
  import wdma_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [2:0]        regAddr,
  input logic              xferStb,
  input logic              memWeN,
  input logic              memOeN,
  input logic [ADDR_W-1:0] memAddr,
  input logic [PROF_W-1:0] clkSel,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] remCnt,
  input logic [ADDR_W-1:0] finalAddr
);

  logic ctrlWr;
  assign ctrlWr = regWrEn && (regAddr == REG_CTRL);

  // R9: idle engine never enables the SRAM
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (memWeN && memOeN));

  // R4: an accepted word steps the address by one
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (busy && xferStb && !ctrlWr) |=> (memAddr == $past(memAddr) + 1'b1));

  // R7: the last counted word ends the run
  a_r7_count_end: assert property (@(posedge clk) disable iff (!rstN)
    (busy && xferStb && !ctrlWr && remCnt == 1) |=> (!busy && done));

  // R8: the word at the window end ends the run
  a_r8_window_end: assert property (@(posedge clk) disable iff (!rstN)
    (busy && xferStb && !ctrlWr && memAddr == finalAddr) |=> (!busy && done));

  // R10: busy and done are never reported together
  a_r10_busy_done_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  // R11: profile moves only on a control write
  a_r11_profile_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWr |=> $stable(clkSel));

  // R5: the two SRAM enables are never active together
  a_r5_enables_excl: assert property (@(posedge clk) disable iff (!rstN)
    (memWeN || memOeN));

endmodule

bind wdma_engine wdma_engine_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .xferStb(xferStb), .memWeN(memWeN), .memOeN(memOeN), .memAddr(memAddr),
  .clkSel(clkSel), .busy(busy), .done(done), .remCnt(remCnt),
  .finalAddr(finalAddr)
);

// File: tb/wdma_engine_test.sv
module wdma_engine_test;

  localparam int AW = 24;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [2:0]    regAddr = '0;
  logic [AW-1:0] regWrData = '0;
  logic [AW-1:0] regRdData;
  logic          xferStb = 1'b0;
  logic [DW-1:0] devDataIn = '0;
  logic [DW-1:0] devDataOut;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memDataIn;
  logic [DW-1:0] memDataOut;
  logic          memWeN, memOeN;
  logic [2:0]    clkSel;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  // SRAM stand-in: read data is a function of the address
  assign memDataIn = memAddr[DW-1:0] ^ 16'hA5A5;

  always #5 clk = ~clk;

  wdma_engine uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .xferStb(xferStb),
    .devDataIn(devDataIn), .devDataOut(devDataOut), .memAddr(memAddr),
    .memDataIn(memDataIn), .memDataOut(memDataOut), .memWeN(memWeN),
    .memOeN(memOeN), .clkSel(clkSel)
  );

  typedef struct {
    logic [AW-1:0] addr;
    logic          weN;
    logic          oeN;
    logic [DW-1:0] data;
    string         tag;
  } item_t;

  item_t expQ[$];

  // Bench model of the run, built from the requirements
  logic [AW-1:0] mAddr = '0, mRem = '0, mFinal = '0;
  bit            mBusy = 0, mDir = 0;

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [AW-1:0] d);
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [AW-1:0] exp, input string tag);
    @(posedge clk); #1;
    regAddr = a;
    @(negedge clk);
    chk(regRdData === exp, tag, 32'(regRdData), 32'(exp));
  endtask

  task automatic arm(input logic [AW-1:0] s, input logic [AW-1:0] f,
                     input logic [AW-1:0] c, input logic [7:0] ctl);
    wr(3'd0, s);
    wr(3'd1, f);
    wr(3'd2, c);
    wr(3'd3, AW'(ctl));
    mAddr = s; mRem = c; mFinal = f; mDir = ctl[4];
    mBusy = ctl[7] && (c != 0);
  endtask

  task automatic disarm(input logic [7:0] ctl);
    wr(3'd3, AW'(ctl));
    mBusy = 0; mDir = ctl[4];
  endtask

  // Driver: one strobe cycle, expectation pushed to the scoreboard
  task automatic xfer(input logic [DW-1:0] d, input string tag);
    item_t it;
    @(posedge clk); #1;
    xferStb = 1'b1; devDataIn = d;
    it.addr = mAddr; it.tag = tag;
    if (mBusy) begin
      it.weN  = !mDir;
      it.oeN  = mDir;
      it.data = mDir ? d : (mAddr[DW-1:0] ^ 16'hA5A5);
      if (mRem == 1 || mAddr == mFinal) mBusy = 0;
      mAddr = mAddr + 1;
      mRem  = mRem - 1;
    end else begin
      it.weN = 1'b1; it.oeN = 1'b1; it.data = '0;
    end
    expQ.push_back(it);
    @(posedge clk); #1;
    xferStb = 1'b0;
  endtask

  // Monitor: compares each strobe cycle against the scoreboard
  always @(negedge clk) begin
    if (rstN && xferStb && !ended) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "scoreboard empty", 32'(memAddr), 32'd0);
      end else begin
        item_t e;
        e = expQ.pop_front();
        chk(memAddr === e.addr, {e.tag, " addr"}, 32'(memAddr), 32'(e.addr));
        chk(memWeN === e.weN, {e.tag, " weN"}, 32'(memWeN), 32'(e.weN));
        chk(memOeN === e.oeN, {e.tag, " oeN"}, 32'(memOeN), 32'(e.oeN));
        if (!e.weN)
          chk(memDataOut === e.data, {e.tag, " wdata"}, 32'(memDataOut), 32'(e.data));
        if (!e.oeN)
          chk(devDataOut === e.data, {e.tag, " rdata"}, 32'(devDataOut), 32'(e.data));
      end
    end
  end

  task automatic finish_run();
    ended = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    @(negedge clk);
    chk(memWeN === 1'b1 && memOeN === 1'b1, "R1 enables idle", 32'({memWeN, memOeN}), 32'h3);
    chk(clkSel === 3'd0, "R1 profile", 32'(clkSel), 32'd0);
    for (int i = 0; i < 6; i++) rd(3'(i), '0, "R1 register zero");

    // R2/R3/R5/R8/R11: device-to-memory run ended by the window
    arm(24'h000010, 24'h000013, 24'd10, 8'h95);
    rd(3'd0, 24'h000010, "R2 start readback");
    rd(3'd1, 24'h000013, "R2 final readback");
    rd(3'd2, 24'd10, "R2 count readback");
    rd(3'd3, 24'h95, "R3 armed busy");
    chk(clkSel === 3'd5, "R11 profile out", 32'(clkSel), 32'd5);
    rd(3'd4, 24'h000010, "R3 address loaded");
    rd(3'd5, 24'd10, "R3 count loaded");
    xfer(16'h1111, "R5 write word");
    xfer(16'h2222, "R4 write word");
    xfer(16'h3333, "R5 write word");
    xfer(16'h4444, "R8 window last word");
    rd(3'd3, 24'h55, "R8 done, not busy");
    rd(3'd4, 24'h000014, "R8 address final+1");
    rd(3'd5, 24'd6, "R8 count remains");
    xfer(16'h5555, "R9 strobe after done");
    rd(3'd4, 24'h000014, "R9 address unchanged");

    // R10/R11: a control write clears done
    disarm(8'h12);
    rd(3'd3, 24'h12, "R10 done cleared");
    chk(clkSel === 3'd2, "R11 profile update", 32'(clkSel), 32'd2);

    // R6/R7/R12: memory-to-device run ended by the count
    arm(24'h000100, 24'hFFFFFF, 24'd3, 8'h87);
    xfer(16'h0, "R6 read word");
    rd(3'd4, 24'h000101, "R12 live address");
    rd(3'd5, 24'd2, "R12 live count");
    xfer(16'h0, "R6 read word");
    xfer(16'h0, "R7 last counted word");
    rd(3'd3, 24'h47, "R7 done, not busy");
    rd(3'd5, 24'd0, "R7 count exhausted");

    // R10: zero count finishes at once
    arm(24'h000300, 24'h0003FF, 24'd0, 8'h83);
    rd(3'd3, 24'h43, "R10 zero count done");
    xfer(16'h7777, "R9 strobe with zero count");

    // R13: disarm mid-run; R10 re-arming clears done
    arm(24'h000200, 24'h0002FF, 24'd5, 8'h91);
    rd(3'd3, 24'h91, "R10 rearm clears done");
    xfer(16'hAAAA, "R4 run word");
    xfer(16'hBBBB, "R4 run word");
    disarm(8'h11);
    rd(3'd3, 24'h11, "R13 disarmed");
    xfer(16'hCCCC, "R13 strobe after disarm");
    rd(3'd4, 24'h000202, "R13 address held");
    rd(3'd5, 24'd3, "R13 count held");

    repeat (2) @(posedge clk);
    chk(expQ.size() == 0, "scoreboard drained", 32'(expQ.size()), 32'd0);
    finish_run();
  end

endmodule